// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps a multiplexed-address DRAM alive beside a separate access sequencer. After reset it waits out a power-up pause, then runs a fixed number of wake-up refresh cycles on its own. Until that sequence is complete it holds the sequencer off with a ready flag. From then on it counts clock cycles. Each time a refresh interval expires it asks the sequencer for the memory bus. Once the bus is granted, it runs a refresh cycle in which the column strobe goes low before the row strobe. The memory's internal counter supplies the row, so the address, write-enable and output-enable lines are don't-care and the data pins stay high impedance.

If the grant is late, the intervals that pass are counted as owed refreshes, up to a parameterised ceiling. All owed refreshes are then run back to back while the bus is still held. A system sleep request turns one refresh cycle into self-refresh: both strobes stay low past the sleep threshold, then the column strobe is let go and the row strobe is held low. A wake request raises the row strobe, waits out precharge, runs one refresh at once, and then returns to the periodic schedule.

Top module: `refsch_top`

## Requirements
- R1: During reset, rasN and casN are 1 (both strobes are active low), busReq is 0, initDone is 0 and inSleep is 0.
- R2: After reset, casN falls for the first time exactly PWR_WAIT_CYC cycles after the first clock edge with rstN high. Exactly WAKE_CYCLES refresh cycles then run with busReq held at 0, and initDone rises at the clock edge that ends the last one. initDone never falls afterwards.
- R3: Every refresh cycle drives casN low for CAS_SETUP_CYC cycles while rasN is 1. It then holds both strobes low for RAS_LOW_CYC cycles and raises both together. rasN always stays high for at least PRECH_CYC cycles before it falls.
- R4: Once initDone is 1, casN falls only in the cycle after busGrant was seen high while busReq was 1. While busGrant is held low, no strobe moves.
- R5: With the bus granted at once, one refresh cycle is run every REFRESH_GAP_CYC cycles.
- R6: Intervals that expire while the grant is withheld are counted as owed refreshes, saturating at DEBT_MAX. On grant, exactly that many refreshes run back to back with busReq held at 1 throughout, and busReq then returns to 0.
- R7: A sleepReq pulse while idle and initialised produces a refresh-style cycle in which both strobes stay low for SLEEP_HOLD_CYC cycles. After that, casN returns to 1, rasN stays 0 and inSleep becomes 1.
- R8: While inSleep is 1, rasN stays 0 and no periodic refresh is issued, however long the sleep lasts.
- R9: A wakeReq pulse during sleep raises rasN and clears inSleep at the next edge. casN then falls after exactly PRECH_CYC cycles with both strobes high, for one refresh cycle, after which busReq returns to 0.
- R10: busReq stays 1 from the start of the sleep entry cycle until the refresh that follows wake-up has finished.
- R11: sleepReq before initDone is ignored, and wakeReq outside sleep is ignored. Neither changes the strobes, busReq or inSleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busGrant | input | 1 | Access sequencer hands the memory bus to this block |
| sleepReq | input | 1 | Single-cycle request to enter self-refresh |
| wakeReq | input | 1 | Single-cycle request to leave self-refresh |
| busReq | output | 1 | This block wants, or is holding, the memory bus |
| rasN | output | 1 | Row strobe to the memory, active low |
| casN | output | 1 | Column strobe to the memory, active low |
| initDone | output | 1 | Power-up sequence finished; access sequencer may run |
| inSleep | output | 1 | Memory is in self-refresh |

## Verification
The checks assume that busGrant, once raised, stays high for as long as busReq stays high. They also assume busGrant is never raised while busReq is low. The bench meets both by deriving busGrant from busReq and a permission flag that it changes only while the block is idle or still waiting for the grant. The checks further assume that sleepReq and wakeReq are single-cycle pulses: the bench pulses sleepReq only when no refresh is owed, and sends wakeReq once per sleep.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

  typedef enum logic [3:0] {
    ST_PWR,
    ST_IDLE,
    ST_REQ,
    ST_CASLO,
    ST_RASLO,
    ST_PRE,
    ST_SLPHOLD,
    ST_SLEEP,
    ST_SLPEXIT
  } schedState_t;

  typedef enum logic [2:0] {
    PH_PWR,
    PH_SETUP,
    PH_LOW,
    PH_PRE,
    PH_SLEEP
  } phaseSel_t;

  typedef struct packed {
    logic      phaseLoad;
    phaseSel_t phaseSel;
    logic      tickRun;
    logic      debtDec;
    logic      debtSet1;
    logic      debtClr;
    logic      wakeDec;
  } strobe_t;

endpackage

// File: rtl/refsch_dp.sv
module refsch_dp
  import refsch_pkg::*;
#(
  parameter int PWR_WAIT_CYC    = 10000,
  parameter int REFRESH_GAP_CYC = 780,
  parameter int CAS_SETUP_CYC   = 1,
  parameter int RAS_LOW_CYC     = 3,
  parameter int PRECH_CYC       = 2,
  parameter int WAKE_CYCLES     = 8,
  parameter int SLEEP_HOLD_CYC  = 5001,
  parameter int DEBT_MAX        = 7
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  output logic    phaseDone,
  output logic    debtAny,
  output logic    debtMore,
  output logic    wakeLast
);

  localparam int MAX_A   = (PWR_WAIT_CYC > SLEEP_HOLD_CYC) ? PWR_WAIT_CYC : SLEEP_HOLD_CYC;
  localparam int MAX_B   = (CAS_SETUP_CYC > RAS_LOW_CYC) ? CAS_SETUP_CYC : RAS_LOW_CYC;
  localparam int MAX_C   = (MAX_B > PRECH_CYC) ? MAX_B : PRECH_CYC;
  localparam int MAX_LEN = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int PH_W    = $clog2(MAX_LEN + 1);
  localparam int IV_W    = (REFRESH_GAP_CYC > 1) ? $clog2(REFRESH_GAP_CYC) : 1;
  localparam int DEBT_W  = $clog2(DEBT_MAX + 1);
  localparam int WK_W    = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;

  localparam logic [PH_W-1:0] LD_PWR   = PH_W'(PWR_WAIT_CYC - 1);
  localparam logic [PH_W-1:0] LD_SETUP = PH_W'(CAS_SETUP_CYC - 1);
  localparam logic [PH_W-1:0] LD_LOW   = PH_W'(RAS_LOW_CYC - 1);
  localparam logic [PH_W-1:0] LD_PRE   = PH_W'(PRECH_CYC - 1);
  localparam logic [PH_W-1:0] LD_SLEEP = PH_W'(SLEEP_HOLD_CYC - 1);
  localparam logic [IV_W-1:0] IV_LAST  = IV_W'(REFRESH_GAP_CYC - 1);
  localparam logic [DEBT_W-1:0] DEBT_TOP = DEBT_W'(DEBT_MAX);

  logic [PH_W-1:0]   phaseCnt;
  logic [PH_W-1:0]   phaseLoadVal;
  logic [IV_W-1:0]   ivCnt;
  logic              tick;
  logic [DEBT_W-1:0] debt;
  logic [DEBT_W-1:0] debtNext;
  logic [DEBT_W-1:0] debtAfterDec;
  logic [WK_W-1:0]   wakeCnt;

  // phase timer: one shared down counter for every timed state
  always_comb begin
    unique case (strb.phaseSel)
      PH_PWR:   phaseLoadVal = LD_PWR;
      PH_SETUP: phaseLoadVal = LD_SETUP;
      PH_LOW:   phaseLoadVal = LD_LOW;
      PH_PRE:   phaseLoadVal = LD_PRE;
      default:  phaseLoadVal = LD_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)               phaseCnt <= LD_PWR;
    else if (strb.phaseLoad) phaseCnt <= phaseLoadVal;
    else if (phaseCnt != '0) phaseCnt <= phaseCnt - PH_W'(1);
  end

  assign phaseDone = (phaseCnt == '0);

  // refresh interval timer
  assign tick = strb.tickRun && (ivCnt == IV_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || !strb.tickRun) ivCnt <= '0;
    else if (tick)              ivCnt <= '0;
    else                        ivCnt <= ivCnt + IV_W'(1);
  end

  // owed-refresh counter, saturating
  always_comb begin
    debtAfterDec = debt;
    if (strb.debtDec && debt != '0) debtAfterDec = debt - DEBT_W'(1);
    debtNext = debtAfterDec;
    if (tick && debtAfterDec != DEBT_TOP) debtNext = debtAfterDec + DEBT_W'(1);
    if (strb.debtSet1) debtNext = DEBT_W'(1);
    if (strb.debtClr)  debtNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) debt <= '0;
    else       debt <= debtNext;
  end

  assign debtAny  = (debt != '0);
  assign debtMore = (debt > DEBT_W'(1));

  // wake-up cycle counter
  always_ff @(posedge clk) begin
    if (!rstN)                            wakeCnt <= WK_W'(WAKE_CYCLES - 1);
    else if (strb.wakeDec && !wakeLast)   wakeCnt <= wakeCnt - WK_W'(1);
  end

  assign wakeLast = (wakeCnt == '0);

endmodule

// File: rtl/refsch_ctrl.sv
module refsch_ctrl
  import refsch_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    busGrant,
  input  logic    sleepReq,
  input  logic    wakeReq,
  input  logic    phaseDone,
  input  logic    debtAny,
  input  logic    debtMore,
  input  logic    wakeLast,
  output strobe_t strb,
  output logic    busReq,
  output logic    rasN,
  output logic    casN,
  output logic    initDone,
  output logic    inSleep
);

  schedState_t st, stNext;
  logic sleepPend, sleepSet, sleepClr, initSet, initNext;

  always_comb begin
    stNext   = st;
    strb     = '0;
    sleepSet = 1'b0;
    sleepClr = 1'b0;
    initSet  = 1'b0;
    strb.tickRun = initDone && (st != ST_SLPHOLD) && (st != ST_SLEEP) && (st != ST_SLPEXIT);
    unique case (st)
      ST_PWR: if (phaseDone) begin
        stNext = ST_CASLO; strb.phaseLoad = 1'b1; strb.phaseSel = PH_SETUP;
      end
      ST_IDLE: begin
        if (sleepReq) begin
          stNext = ST_REQ; sleepSet = 1'b1;
        end else if (debtAny) begin
          stNext = ST_REQ;
        end
      end
      ST_REQ: if (busGrant) begin
        stNext = ST_CASLO; strb.phaseLoad = 1'b1; strb.phaseSel = PH_SETUP;
      end
      ST_CASLO: if (phaseDone) begin
        strb.phaseLoad = 1'b1;
        if (sleepPend) begin
          stNext = ST_SLPHOLD; strb.phaseSel = PH_SLEEP;
        end else begin
          stNext = ST_RASLO; strb.phaseSel = PH_LOW;
        end
      end
      ST_RASLO: if (phaseDone) begin
        stNext = ST_PRE; strb.phaseLoad = 1'b1; strb.phaseSel = PH_PRE;
      end
      ST_PRE: if (phaseDone) begin
        if (!initDone) begin
          strb.wakeDec = 1'b1;
          if (wakeLast) begin
            stNext = ST_IDLE; initSet = 1'b1;
          end else begin
            stNext = ST_CASLO; strb.phaseLoad = 1'b1; strb.phaseSel = PH_SETUP;
          end
        end else begin
          strb.debtDec = 1'b1;
          if (debtMore) begin
            stNext = ST_CASLO; strb.phaseLoad = 1'b1; strb.phaseSel = PH_SETUP;
          end else begin
            stNext = ST_IDLE;
          end
        end
      end
      ST_SLPHOLD: begin
        strb.debtClr = 1'b1;
        if (phaseDone) stNext = ST_SLEEP;
      end
      ST_SLEEP: begin
        strb.debtClr = 1'b1;
        if (wakeReq) begin
          stNext = ST_SLPEXIT; strb.phaseLoad = 1'b1; strb.phaseSel = PH_PRE;
        end
      end
      ST_SLPEXIT: if (phaseDone) begin
        stNext = ST_CASLO; strb.phaseLoad = 1'b1; strb.phaseSel = PH_SETUP;
        strb.debtSet1 = 1'b1; sleepClr = 1'b1;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  assign initNext = initDone | initSet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= ST_PWR;
      sleepPend <= 1'b0;
      initDone  <= 1'b0;
      rasN      <= 1'b1;
      casN      <= 1'b1;
      busReq    <= 1'b0;
      inSleep   <= 1'b0;
    end else begin
      st        <= stNext;
      initDone  <= initNext;
      if (sleepSet)      sleepPend <= 1'b1;
      else if (sleepClr) sleepPend <= 1'b0;
      rasN    <= !(stNext inside {ST_RASLO, ST_SLPHOLD, ST_SLEEP});
      casN    <= !(stNext inside {ST_CASLO, ST_RASLO, ST_SLPHOLD});
      busReq  <= initNext && !(stNext inside {ST_PWR, ST_IDLE});
      inSleep <= (stNext == ST_SLEEP);
    end
  end

endmodule

// File: rtl/refsch_top.sv
module refsch_top
  import refsch_pkg::*;
#(
  parameter int PWR_WAIT_CYC    = 10000,
  parameter int REFRESH_GAP_CYC = 780,
  parameter int CAS_SETUP_CYC   = 1,
  parameter int RAS_LOW_CYC     = 3,
  parameter int PRECH_CYC       = 2,
  parameter int WAKE_CYCLES     = 8,
  parameter int SLEEP_HOLD_CYC  = 5001,
  parameter int DEBT_MAX        = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic busGrant,
  input  logic sleepReq,
  input  logic wakeReq,
  output logic busReq,
  output logic rasN,
  output logic casN,
  output logic initDone,
  output logic inSleep
);

  strobe_t strb;
  logic phaseDone, debtAny, debtMore, wakeLast;

  refsch_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .busGrant(busGrant), .sleepReq(sleepReq),
    .wakeReq(wakeReq), .phaseDone(phaseDone), .debtAny(debtAny),
    .debtMore(debtMore), .wakeLast(wakeLast), .strb(strb), .busReq(busReq),
    .rasN(rasN), .casN(casN), .initDone(initDone), .inSleep(inSleep)
  );

  refsch_dp #(
    .PWR_WAIT_CYC(PWR_WAIT_CYC), .REFRESH_GAP_CYC(REFRESH_GAP_CYC),
    .CAS_SETUP_CYC(CAS_SETUP_CYC), .RAS_LOW_CYC(RAS_LOW_CYC),
    .PRECH_CYC(PRECH_CYC), .WAKE_CYCLES(WAKE_CYCLES),
    .SLEEP_HOLD_CYC(SLEEP_HOLD_CYC), .DEBT_MAX(DEBT_MAX)
  ) dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .phaseDone(phaseDone),
    .debtAny(debtAny), .debtMore(debtMore), .wakeLast(wakeLast)
  );

endmodule

// File: rtl/refsch_chk.sv
module refsch_chk #(
  parameter int PRECH_CYC = 2
) (
  input logic clk,
  input logic rstN,
  input logic busGrant,
  input logic busReq,
  input logic rasN,
  input logic casN,
  input logic initDone,
  input logic inSleep
);

  logic [15:0] highRun;

  always_ff @(posedge clk) begin
    if (!rstN)                 highRun <= '0;
    else if (!rasN)            highRun <= '0;
    else if (highRun != '1)    highRun <= highRun + 16'd1;
  end

  // R3
  cas_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!casN && $past(!casN)));

  // R3
  joint_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(casN) |-> (rasN || inSleep));

  // R3
  prech_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (highRun >= 16'(PRECH_CYC)));

  // R4
  grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(casN) && initDone && $past(initDone)) |-> ($past(busGrant) && $past(busReq)));

  // R2
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> !busReq);

  // R2
  init_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(initDone) |-> initDone);

  // R8
  sleep_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    inSleep |-> !rasN);

  // R10
  sleep_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    inSleep |-> busReq);

endmodule

bind refsch_top refsch_chk #(.PRECH_CYC(PRECH_CYC)) chkI (
  .clk(clk), .rstN(rstN), .busGrant(busGrant), .busReq(busReq),
  .rasN(rasN), .casN(casN), .initDone(initDone), .inSleep(inSleep)
);

// File: tb/tb_refsch_top.sv
module tb_refsch_top;

  localparam int PWR   = 50;
  localparam int GAP   = 40;
  localparam int SETUP = 2;
  localparam int LOW   = 3;
  localparam int PRE   = 2;
  localparam int WAKES = 8;
  localparam int SLP   = 60;
  localparam int DMAX  = 4;

  typedef enum int {K_INIT, K_NORM, K_SLEEP} kind_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic grantOn = 1'b0;
  logic sleepReq = 1'b0;
  logic wakeReq = 1'b0;
  logic busGrant, busReq, rasN, casN, initDone, inSleep;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int firstCasCyc = -1;
  bit finished = 1'b0;
  kind_t expQ[$];

  always #10 clk = ~clk;

  assign busGrant = grantOn & busReq;

  refsch_top #(
    .PWR_WAIT_CYC(PWR), .REFRESH_GAP_CYC(GAP), .CAS_SETUP_CYC(SETUP),
    .RAS_LOW_CYC(LOW), .PRECH_CYC(PRE), .WAKE_CYCLES(WAKES),
    .SLEEP_HOLD_CYC(SLP), .DEBT_MAX(DMAX)
  ) dut (
    .clk(clk), .rstN(rstN), .busGrant(busGrant), .sleepReq(sleepReq),
    .wakeReq(wakeReq), .busReq(busReq), .rasN(rasN), .casN(casN),
    .initDone(initDone), .inSleep(inSleep)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic untilCyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic pushExp(input kind_t k, input int n);
    for (int i = 0; i < n; i++) expQ.push_back(k);
  endtask

  always @(posedge clk) if (rstN) cyc++;

  // monitor: measure every row-strobe pulse and compare against the queue
  int casRun = 0, setupLen = 0, bothLen = 0, rasLowLen = 0;
  bit busSeen = 1'b0;
  logic prevRas = 1'b1;
  always @(negedge clk) begin
    if (rstN) begin
      if (!casN && firstCasCyc < 0) firstCasCyc = cyc;
      if (prevRas && !rasN) begin
        setupLen = casRun; bothLen = 0; rasLowLen = 0; busSeen = 1'b0;
      end
      if (!rasN) begin
        rasLowLen++;
        if (!casN) bothLen++;
        if (busReq) busSeen = 1'b1;
      end
      if (!prevRas && rasN) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R5", "unexpected refresh pulse", 1, 0);
        end else begin
          kind_t k;
          k = expQ.pop_front();
          // R3 shape of every cycle
          chk(setupLen == SETUP, "R3", "cas lead cycles", setupLen, SETUP);
          if (k == K_SLEEP) begin
            chk(bothLen == SLP, "R7", "sleep hold cycles", bothLen, SLP);
            chk(rasLowLen > bothLen, "R7", "ras held after cas release", rasLowLen, bothLen + 1);
          end else begin
            chk(bothLen == LOW && rasLowLen == LOW, "R3", "both-low cycles", bothLen, LOW);
            if (k == K_INIT) chk(!busSeen, "R2", "busReq during wake-up cycle", int'(busSeen), 0);
            else             chk(busSeen, "R4", "busReq during refresh", int'(busSeen), 1);
          end
        end
      end
      if (rasN && !casN) casRun++;
      else               casRun = 0;
      prevRas = rasN;
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    int highCnt;
    int rasHigh;
    cycles(3);
    // R1 reset values
    chk(rasN == 1'b1, "R1", "rasN in reset", int'(rasN), 1);
    chk(casN == 1'b1, "R1", "casN in reset", int'(casN), 1);
    chk(busReq == 1'b0, "R1", "busReq in reset", int'(busReq), 0);
    chk(initDone == 1'b0, "R1", "initDone in reset", int'(initDone), 0);
    chk(inSleep == 1'b0, "R1", "inSleep in reset", int'(inSleep), 0);
    pushExp(K_INIT, WAKES);
    rstN = 1'b1;

    // R11 early sleep request must be ignored
    untilCyc(10);
    sleepReq = 1'b1; cycles(1); sleepReq = 1'b0;

    untilCyc(PWR + 55);
    chk(initDone == 1'b0, "R2", "initDone before last wake cycle", int'(initDone), 0);
    cycles(1);
    chk(initDone == 1'b1, "R2", "initDone after wake cycles", int'(initDone), 1);
    chk(firstCasCyc == PWR, "R2", "first casN fall cycle", firstCasCyc, PWR);
    chk(expQ.size() == 0, "R2", "wake-up cycles left", expQ.size(), 0);
    chk(inSleep == 1'b0, "R11", "inSleep after early sleepReq", int'(inSleep), 0);
    base = cyc;

    // R5 periodic refresh with immediate grant
    grantOn = 1'b1;
    pushExp(K_NORM, 5);
    untilCyc(base + 20);
    wakeReq = 1'b1; cycles(1); wakeReq = 1'b0;
    chk(rasN && casN && !busReq, "R11", "wakeReq outside sleep moved outputs", int'(busReq), 0);
    untilCyc(base + 212);
    chk(expQ.size() == 0, "R5", "periodic refreshes outstanding", expQ.size(), 0);

    // R4 / R6 withheld grant accumulates owed refreshes
    grantOn = 1'b0;
    untilCyc(base + 523);
    chk(busReq == 1'b1, "R4", "busReq while waiting", int'(busReq), 1);
    chk(casN == 1'b1 && rasN == 1'b1, "R4", "strobes idle without grant", int'(casN), 1);
    pushExp(K_NORM, DMAX);
    untilCyc(base + 524);
    grantOn = 1'b1;
    highCnt = 0;
    for (int i = 0; i < 26; i++) begin
      cycles(1);
      if (busReq) highCnt++;
    end
    chk(highCnt == 26, "R6", "busReq held through burst", highCnt, 26);
    untilCyc(base + 555);
    chk(expQ.size() == 0, "R6", "burst refreshes outstanding", expQ.size(), 0);
    chk(busReq == 1'b0, "R6", "busReq after burst", int'(busReq), 0);

    // R7 sleep entry
    pushExp(K_SLEEP, 1);
    sleepReq = 1'b1; cycles(1); sleepReq = 1'b0;
    for (int i = 0; i < 100 && !inSleep; i++) cycles(1);
    chk(inSleep == 1'b1, "R7", "inSleep after hold", int'(inSleep), 1);
    chk(rasN == 1'b0 && casN == 1'b1, "R7", "strobes in sleep (casN)", int'(casN), 1);
    chk(busReq == 1'b1, "R10", "busReq in sleep", int'(busReq), 1);

    // R8 long sleep, no refresh, row strobe held
    rasHigh = 0;
    for (int i = 0; i < 5 * GAP; i++) begin
      cycles(1);
      if (rasN) rasHigh++;
    end
    chk(rasHigh == 0, "R8", "rasN high samples in sleep", rasHigh, 0);

    // R9 wake and single refresh
    pushExp(K_NORM, 1);
    wakeReq = 1'b1; cycles(1); wakeReq = 1'b0;
    chk(rasN == 1'b1 && inSleep == 1'b0, "R9", "rasN after wake", int'(rasN), 1);
    cycles(1);
    chk(casN == 1'b1, "R9", "casN during precharge", int'(casN), 1);
    chk(busReq == 1'b1, "R10", "busReq during precharge", int'(busReq), 1);
    cycles(1);
    chk(casN == 1'b0 && rasN == 1'b1, "R9", "casN fall after precharge", int'(casN), 0);
    cycles(10);
    chk(expQ.size() == 0, "R9", "refreshes outstanding after wake", expQ.size(), 0);
    chk(busReq == 1'b0, "R9", "busReq after wake refresh", int'(busReq), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule